// File: doc/BRIEF.md
# NAND Host Bus Bridge

This block connects a 16-bit host register bus to an 8-bit NAND flash device. The host sees five byte registers: a data port, a mode byte, a status byte, an interrupt-pending byte and an interrupt-enable byte. One write to the mode byte sets the command latch, address latch and chip-enable lines, and gates write strobes. After that, accesses to the data port turn into NAND byte cycles. A 16-bit access becomes two byte cycles with the low byte first. An 8-bit access becomes one byte cycle.

Each byte cycle holds a strobe low for a set number of clocks (never fewer than two), then keeps it high for one recovery clock. A sequencer with four states does this work. IDLE waits for a request. STROBE holds read-enable or write-enable low. GAP is the recovery clock. FINISH returns the result. The transitions are:
- IDLE→STROBE when a permitted data access is accepted.
- IDLE→FINISH for a register access or a refused data access.
- STROBE→GAP after the last low clock.
- GAP→STROBE for the second byte of a wide access.
- GAP→FINISH otherwise.
- FINISH→IDLE always.

The ready/busy pin is synchronised. It is shown in the status byte, and its rising edge sets a sticky ready flag that can drive the interrupt line.

Top module: `nand_bridge`

## Requirements
- R1: After reset, nand_ce_n, nand_we_n and nand_re_n are 1, nand_cle, nand_ale, irq, bus_done and bus_busy are 0, and the mode byte (offset 4) reads 0x00.
- R2: Mode byte bit 0 drives nand_cle, bit 1 drives nand_ale, and bit 4 set drives nand_ce_n low. The byte reads back at offset 4. Value 0x95 selects the command phase, 0x96 the address phase, 0x94 the data phase and 0x00 standby.
- R3: A 16-bit write to offset 0 gives two write-enable pulses. The first carries bus_wdata[7:0] and the second carries bus_wdata[15:8].
- R4: An 8-bit write to offset 0 gives exactly one write-enable pulse, carrying bus_wdata[7:0], with the latch lines set by the current mode.
- R5: A 16-bit read of offset 0 gives two read-enable pulses. The first byte returns in bus_rdata[7:0] and the second in bus_rdata[15:8]. An 8-bit read gives one pulse, with the byte in bits 7:0 and zeros above.
- R6: Every strobe stays low for max(2, STROBE_CYC) clocks. Two strobes of one access are separated by exactly one high clock. Read and write strobes are never low together.
- R7: A data write while mode bit 4 or bit 7 is clear, or a data read while bit 4 is clear, produces no strobe but still completes. Such a read returns 0.
- R8: Status byte (offset 5) bit 7 reads 1 while nand_rb is low. It reflects a change of nand_rb within three clocks, and its other bits read 0.
- R9: A rising edge on nand_rb sets bit 0 of the pending byte (offset 6), whatever the enable byte holds. The bit stays set until it is cleared.
- R10: irq is 1 exactly when the ready flag is pending and the enable byte (offset 7) has both bit 7 and bit 0 set. Writing 0x00 to offset 7 drops irq on the next clock.
- R11: Writing a byte to offset 6 clears each pending bit where that byte has a 1. Writing 0x0f clears all of them.
- R12: bus_req is taken only while bus_busy is 0. Each accepted access ends with one bus_done pulse that carries valid bus_rdata. A register access raises bus_done in the second clock after acceptance.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_req | input | 1 | Access request, sampled while bus_busy is 0 |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_wide | input | 1 | 1 = 16-bit data access, 0 = 8-bit |
| bus_addr | input | 3 | Register offset (0 data, 4 mode, 5 status, 6 pending, 7 enable) |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data, valid with bus_done |
| bus_busy | output | 1 | Access in progress |
| bus_done | output | 1 | One-clock completion pulse |
| nand_cle | output | 1 | Command latch enable |
| nand_ale | output | 1 | Address latch enable |
| nand_ce_n | output | 1 | Chip enable, active low |
| nand_we_n | output | 1 | Write strobe, active low |
| nand_re_n | output | 1 | Read strobe, active low |
| nand_dout | output | 8 | Byte driven to the device |
| nand_doe | output | 1 | Output enable for nand_dout |
| nand_din | input | 8 | Byte from the device |
| nand_rb | input | 1 | Ready (1) / busy (0) |
| irq | output | 1 | Ready interrupt |

## Verification
A sequencer stuck in the wrong state shows up at once on the bus. bus_done fails to arrive or arrives early, or the count and width of strobes seen by the flash model is off within the same access. A wrong byte index shows up as swapped halves in the model's write log or in bus_rdata on the next wide access. A fault in the ready path shows as a wrong status bit or a missing or stray irq within three clocks of a ready/busy change.

// File: rtl/nand_bridge_pkg.sv
package nand_bridge_pkg;
    typedef enum logic [1:0] {
        S_IDLE,
        S_STROBE,
        S_GAP,
        S_FINISH
    } seq_state_t;

    localparam logic [2:0] OFS_DATA = 3'd0;
    localparam logic [2:0] OFS_MODE = 3'd4;
    localparam logic [2:0] OFS_STAT = 3'd5;
    localparam logic [2:0] OFS_PEND = 3'd6;
    localparam logic [2:0] OFS_ENAB = 3'd7;

    localparam int MODE_CLE_BIT  = 0;
    localparam int MODE_ALE_BIT  = 1;
    localparam int MODE_CE_BIT   = 4;
    localparam int MODE_WGATE_BIT = 7;
endpackage

// File: rtl/nand_bridge_sync.sv
module nand_bridge_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic async_in,
    output logic level,
    output logic rise
);
    logic [STAGES:0] chain;

    always_ff @(posedge clk) begin
        if (!rst_n) chain <= '1;
        else        chain <= {chain[STAGES-1:0], async_in};
    end

    assign level = chain[STAGES-1];
    assign rise  = chain[STAGES-1] & ~chain[STAGES];
endmodule

// File: rtl/nand_bridge_regs.sv
module nand_bridge_regs
    import nand_bridge_pkg::*;
#(
    parameter int PEND_W = 4
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       wr_en,
    input  logic [2:0] addr,
    input  logic [7:0] wdata,
    input  logic       rb_level,
    input  logic       rb_rise,
    output logic [7:0] mode,
    output logic [7:0] rd_byte,
    output logic       irq
);
    logic [7:0]        enab;
    logic [PEND_W-1:0] pend;
    logic [PEND_W-1:0] pend_set;

    assign pend_set = {{(PEND_W-1){1'b0}}, rb_rise};

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode <= 8'h00;
            enab <= 8'h00;
            pend <= '0;
        end else begin
            if (wr_en && addr == OFS_MODE) mode <= wdata;
            if (wr_en && addr == OFS_ENAB) enab <= wdata;
            if (wr_en && addr == OFS_PEND) pend <= (pend & ~wdata[PEND_W-1:0]) | pend_set;
            else                            pend <= pend | pend_set;
        end
    end

    always_comb begin
        unique case (addr)
            OFS_MODE: rd_byte = mode;
            OFS_STAT: rd_byte = {~rb_level, 7'b0};
            OFS_PEND: rd_byte = {{(8-PEND_W){1'b0}}, pend};
            OFS_ENAB: rd_byte = enab;
            default:  rd_byte = 8'h00;
        endcase
    end

    assign irq = pend[0] & enab[7] & enab[0];
endmodule

// File: rtl/nand_bridge_seq.sv
module nand_bridge_seq
    import nand_bridge_pkg::*;
#(
    parameter int LOW_CYC = 3
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        req,
    input  logic        wr,
    input  logic        wide,
    input  logic        is_data,
    input  logic        allow,
    input  logic [15:0] wdata,
    input  logic [7:0]  reg_byte,
    input  logic [7:0]  din,
    output logic        accept,
    output logic        we_n,
    output logic        re_n,
    output logic [7:0]  dout,
    output logic        doe,
    output logic        busy,
    output logic        done,
    output logic [15:0] rdata
);
    localparam int CW = $clog2(LOW_CYC + 1);

    seq_state_t state, state_nx;
    logic [CW-1:0] cnt;
    logic          idx, dir_wr, two;
    logic [15:0]   wbuf;

    assign accept = req && state == S_IDLE;

    always_comb begin
        state_nx = state;
        unique case (state)
            S_IDLE:   if (req) state_nx = (is_data && allow) ? S_STROBE : S_FINISH;
            S_STROBE: if (cnt == CW'(LOW_CYC - 1)) state_nx = S_GAP;
            S_GAP:    state_nx = (two && !idx) ? S_STROBE : S_FINISH;
            S_FINISH: state_nx = S_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state  <= S_IDLE;
            cnt    <= '0;
            idx    <= 1'b0;
            dir_wr <= 1'b0;
            two    <= 1'b0;
            wbuf   <= '0;
            rdata  <= '0;
        end else begin
            state <= state_nx;
            unique case (state)
                S_IDLE: if (req) begin
                    cnt    <= '0;
                    idx    <= 1'b0;
                    dir_wr <= wr;
                    two    <= wide;
                    wbuf   <= wdata;
                    rdata  <= is_data ? 16'h0000 : {8'h00, reg_byte};
                end
                S_STROBE: begin
                    cnt <= cnt + 1'b1;
                    if (cnt == CW'(LOW_CYC - 1) && !dir_wr) begin
                        if (idx) rdata[15:8] <= din;
                        else     rdata[7:0]  <= din;
                    end
                end
                S_GAP: begin
                    cnt <= '0;
                    idx <= 1'b1;
                end
                S_FINISH: ;
            endcase
        end
    end

    always_comb begin
        we_n = 1'b1;
        re_n = 1'b1;
        doe  = 1'b0;
        unique case (state)
            S_STROBE: begin
                we_n = ~dir_wr;
                re_n = dir_wr;
                doe  = dir_wr;
            end
            S_GAP:    doe = dir_wr;
            S_IDLE, S_FINISH: ;
        endcase
    end

    assign dout = idx ? wbuf[15:8] : wbuf[7:0];
    assign busy = state != S_IDLE;
    assign done = state == S_FINISH;
endmodule

// File: rtl/nand_bridge.sv
module nand_bridge
    import nand_bridge_pkg::*;
#(
    parameter int STROBE_CYC = 3,
    parameter int SYNC_STAGES = 2
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        bus_req,
    input  logic        bus_wr,
    input  logic        bus_wide,
    input  logic [2:0]  bus_addr,
    input  logic [15:0] bus_wdata,
    output logic [15:0] bus_rdata,
    output logic        bus_busy,
    output logic        bus_done,
    output logic        nand_cle,
    output logic        nand_ale,
    output logic        nand_ce_n,
    output logic        nand_we_n,
    output logic        nand_re_n,
    output logic [7:0]  nand_dout,
    output logic        nand_doe,
    input  logic [7:0]  nand_din,
    input  logic        nand_rb,
    output logic        irq
);
    localparam int LOW_CYC = (STROBE_CYC < 2) ? 2 : STROBE_CYC;

    logic       rb_level, rb_rise, accept, is_data, allow;
    logic [7:0] mode, reg_byte;

    nand_bridge_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst_n(rst_n), .async_in(nand_rb),
        .level(rb_level), .rise(rb_rise)
    );

    assign is_data = bus_addr == OFS_DATA;
    assign allow   = mode[MODE_CE_BIT] & (~bus_wr | mode[MODE_WGATE_BIT]);

    nand_bridge_regs u_regs (
        .clk(clk), .rst_n(rst_n),
        .wr_en(accept && bus_wr && !is_data),
        .addr(bus_addr), .wdata(bus_wdata[7:0]),
        .rb_level(rb_level), .rb_rise(rb_rise),
        .mode(mode), .rd_byte(reg_byte), .irq(irq)
    );

    nand_bridge_seq #(.LOW_CYC(LOW_CYC)) u_seq (
        .clk(clk), .rst_n(rst_n),
        .req(bus_req), .wr(bus_wr), .wide(bus_wide),
        .is_data(is_data), .allow(allow),
        .wdata(bus_wdata), .reg_byte(reg_byte), .din(nand_din),
        .accept(accept),
        .we_n(nand_we_n), .re_n(nand_re_n),
        .dout(nand_dout), .doe(nand_doe),
        .busy(bus_busy), .done(bus_done), .rdata(bus_rdata)
    );

    assign nand_cle  = mode[MODE_CLE_BIT];
    assign nand_ale  = mode[MODE_ALE_BIT];
    assign nand_ce_n = ~mode[MODE_CE_BIT];
endmodule

// File: rtl/nand_bridge_chk.sv
module nand_bridge_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        bus_req,
    input logic        bus_wr,
    input logic        bus_busy,
    input logic [2:0]  bus_addr,
    input logic [15:0] bus_wdata,
    input logic        bus_done,
    input logic        nand_ce_n,
    input logic        nand_we_n,
    input logic        nand_re_n,
    input logic        irq
);
    p_strobe_excl_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !(!nand_we_n && !nand_re_n));

    p_we_width_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(nand_we_n) |-> !$past(nand_we_n, 2));

    p_re_width_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(nand_re_n) |-> !$past(nand_re_n, 2));

    p_strobe_needs_ce_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (!nand_we_n || !nand_re_n) |-> !nand_ce_n);

    p_done_pulse_r12: assert property (@(posedge clk) disable iff (!rst_n)
        bus_done |=> !bus_done);

    p_mask_off_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_req && !bus_busy && bus_wr && bus_addr == 3'd7 && bus_wdata[7:0] == 8'h00)
        |=> !irq);
endmodule

bind nand_bridge nand_bridge_chk u_chk (
    .clk(clk), .rst_n(rst_n), .bus_req(bus_req), .bus_wr(bus_wr),
    .bus_busy(bus_busy), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_done(bus_done), .nand_ce_n(nand_ce_n), .nand_we_n(nand_we_n),
    .nand_re_n(nand_re_n), .irq(irq)
);

// File: tb/nand_bridge_tb.sv
module nand_bridge_tb;
    localparam int CLK_PERIOD = 10;
    localparam int STROBE = 3;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_req = 1'b0, bus_wr = 1'b0, bus_wide = 1'b0;
    logic [2:0]  bus_addr = '0;
    logic [15:0] bus_wdata = '0;
    logic [15:0] bus_rdata;
    logic        bus_busy, bus_done;
    logic        nand_cle, nand_ale, nand_ce_n, nand_we_n, nand_re_n, nand_doe;
    logic [7:0]  nand_dout, nand_din;
    logic        nand_rb = 1'b1;
    logic        irq;

    int checks = 0, fails = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    nand_bridge #(.STROBE_CYC(STROBE)) u_dut (.*);

    // flash stub
    int unsigned rptr = 0, wcnt = 0;
    logic [7:0] log_b [0:255];
    logic [1:0] log_l [0:255];

    function automatic logic [7:0] pat(int unsigned p);
        return 8'((p * 37 + 5) & 8'hff);
    endfunction

    assign nand_din = nand_re_n ? 8'hzz : pat(rptr);
    always @(posedge nand_re_n) rptr <= rptr + 1;
    always @(posedge nand_we_n) begin
        log_b[wcnt[7:0]] <= nand_dout;
        log_l[wcnt[7:0]] <= {nand_ale, nand_cle};
        wcnt <= wcnt + 1;
    end

    // strobe width monitor
    int lo_run = 0, hi_run = 0, wmin = 99, wmax = 0, gap_last = 0;
    always @(posedge clk) begin
        if (!nand_we_n || !nand_re_n) begin
            if (lo_run == 0 && hi_run > 0 && hi_run < 5) gap_last <= hi_run;
            lo_run <= lo_run + 1;
            hi_run <= 0;
        end else begin
            if (lo_run > 0) begin
                if (lo_run < wmin) wmin <= lo_run;
                if (lo_run > wmax) wmax <= lo_run;
            end
            lo_run <= 0;
            hi_run <= hi_run + 1;
        end
    end

    // watchdog
    int cyc = 0;
    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > 150000) begin
            fails++;
            $display("FAIL watchdog: actual %0d cycles expected < 150000", cyc);
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic access(input logic wr, input logic wide, input logic [2:0] a,
                          input logic [15:0] wd, output logic [15:0] rd, output int lat);
        @(negedge clk);
        bus_req = 1'b1; bus_wr = wr; bus_wide = wide; bus_addr = a; bus_wdata = wd;
        @(negedge clk);
        bus_req = 1'b0;
        lat = 1;
        while (!bus_done && lat < 100) begin
            @(negedge clk);
            lat++;
        end
        rd = bus_rdata;
    endtask

    task automatic wreg(input logic [2:0] a, input logic [15:0] d);
        logic [15:0] r; int l;
        access(1'b1, 1'b0, a, d, r, l);
    endtask

    task automatic rreg(input logic [2:0] a, output logic [15:0] r);
        int l;
        access(1'b0, 1'b0, a, 16'h0, r, l);
    endtask

    int unsigned exp_w = 0;
    logic [7:0] eb [0:255];
    logic [1:0] el [0:255];

    task automatic expect_log(string req);
        chk(req, wcnt, exp_w);
        for (int i = 0; i < int'(exp_w) && i < 256; i++) begin
            if (log_b[i] !== eb[i] || log_l[i] !== el[i])
                chk(req, {22'h0, log_l[i], log_b[i]}, {22'h0, el[i], eb[i]});
        end
    endtask

    initial begin
        logic [15:0] r;
        int lat;
        logic [7:0] m;
        logic [15:0] w;
        void'($urandom(32'h5eed));

        repeat (3) @(negedge clk);
        chk("R1 ce_n/we_n/re_n", {nand_ce_n, nand_we_n, nand_re_n}, 3'b111);
        chk("R1 cle/ale/irq/done/busy", {nand_cle, nand_ale, irq, bus_done, bus_busy}, 5'b0);
        rst_n = 1'b1;
        rreg(3'd4, r);
        chk("R1 mode reset", r, 16'h0000);

        // register access latency
        access(1'b0, 1'b0, 3'd4, 16'h0, r, lat);
        chk("R12 register done latency", lat, 1);

        // mode decode
        wreg(3'd4, 16'h0095);
        @(negedge clk);
        chk("R2 command phase lines", {nand_cle, nand_ale, nand_ce_n}, 3'b100);
        wreg(3'd4, 16'h0096);
        @(negedge clk);
        chk("R2 address phase lines", {nand_cle, nand_ale, nand_ce_n}, 3'b010);
        rreg(3'd4, r);
        chk("R2 mode readback", r, 16'h0096);
        wreg(3'd4, 16'h0000);
        @(negedge clk);
        chk("R2 standby lines", {nand_cle, nand_ale, nand_ce_n}, 3'b001);

        // refused accesses
        wreg(3'd4, 16'h0000);
        access(1'b1, 1'b1, 3'd0, 16'hbeef, r, lat);
        chk("R7 standby write no strobe", wcnt, 0);
        chk("R7 refused write completes", lat < 5, 1);
        wreg(3'd4, 16'h0014);
        access(1'b1, 1'b1, 3'd0, 16'hbeef, r, lat);
        chk("R7 write gate off no strobe", wcnt, 0);
        wreg(3'd4, 16'h0000);
        access(1'b0, 1'b1, 3'd0, 16'h0, r, lat);
        chk("R7 refused read value", r, 16'h0000);
        chk("R7 refused read no strobe", rptr, 0);

        // 8-bit command write
        wreg(3'd4, 16'h0095);
        access(1'b1, 1'b0, 3'd0, 16'h7790, r, lat);
        eb[exp_w] = 8'h90; el[exp_w] = 2'b01; exp_w++;
        expect_log("R4 single command cycle");

        // wide data write and strobe width
        wreg(3'd4, 16'h0094);
        wmin = 99; wmax = 0; gap_last = 0;
        access(1'b1, 1'b1, 3'd0, 16'hA55A, r, lat);
        eb[exp_w] = 8'h5A; el[exp_w] = 2'b00; exp_w++;
        eb[exp_w] = 8'hA5; el[exp_w] = 2'b00; exp_w++;
        expect_log("R3 wide write low byte first");
        chk("R6 strobe min width", wmin, STROBE);
        chk("R6 strobe max width", wmax, STROBE);
        chk("R6 gap between strobes", gap_last, 1);

        // wide and narrow reads
        access(1'b0, 1'b1, 3'd0, 16'h0, r, lat);
        chk("R5 wide read", r, {pat(1), pat(0)});
        access(1'b0, 1'b0, 3'd0, 16'h0, r, lat);
        chk("R5 narrow read", r, {8'h00, pat(2)});

        // random mix
        for (int it = 0; it < 40; it++) begin
            int unsigned op;
            op = $urandom_range(0, 3);
            if (op == 0) begin
                m = ($urandom_range(0, 1) == 0) ? 8'h95 : 8'h96;
                wreg(3'd4, {8'h00, m});
                w = 16'($urandom);
                access(1'b1, 1'b0, 3'd0, w, r, lat);
                eb[exp_w] = w[7:0]; el[exp_w] = m[1:0]; exp_w++;
            end else if (op == 1) begin
                wreg(3'd4, 16'h0094);
                w = 16'($urandom);
                access(1'b1, 1'b1, 3'd0, w, r, lat);
                eb[exp_w] = w[7:0]; el[exp_w] = 2'b00; exp_w++;
                eb[exp_w] = w[15:8]; el[exp_w] = 2'b00; exp_w++;
            end else begin
                int unsigned p;
                wreg(3'd4, 16'h0094);
                p = rptr;
                access(1'b0, 1'b1, 3'd0, 16'h0, r, lat);
                chk("R5 random wide read", r, {pat(p + 1), pat(p)});
            end
        end
        expect_log("R3 R4 random write log");

        // status and ready interrupt
        wreg(3'd6, 16'h000f);
        wreg(3'd7, 16'h0000);
        @(negedge clk); nand_rb = 1'b0;
        repeat (4) @(negedge clk);
        rreg(3'd5, r);
        chk("R8 status busy", r, 16'h0080);
        nand_rb = 1'b1;
        repeat (4) @(negedge clk);
        rreg(3'd5, r);
        chk("R8 status ready", r, 16'h0000);
        rreg(3'd6, r);
        chk("R9 pending set while masked", r, 16'h0001);
        chk("R10 irq masked", irq, 1'b0);
        wreg(3'd7, 16'h0081);
        @(negedge clk);
        chk("R10 irq enabled", irq, 1'b1);
        repeat (5) @(negedge clk);
        chk("R9 pending sticky", irq, 1'b1);
        wreg(3'd7, 16'h0001);
        @(negedge clk);
        chk("R10 partial mask", irq, 1'b0);
        wreg(3'd7, 16'h0081);
        wreg(3'd7, 16'h0000);
        chk("R10 mask off drops irq", irq, 1'b0);
        wreg(3'd7, 16'h0081);
        wreg(3'd6, 16'h0002);
        rreg(3'd6, r);
        chk("R11 unrelated clear keeps bit", r, 16'h0001);
        wreg(3'd6, 16'h000f);
        rreg(3'd6, r);
        chk("R11 clear all", r, 16'h0000);
        chk("R11 irq after clear", irq, 1'b0);

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule